// File: doc/BRIEF.md
# Match-Controlled Timer with Capture

This block is a timer/counter whose count advances on a slow reference strobe. The strobe is a one-cycle pulse in the block's clock domain that marks each period of a 32 kHz real-time reference, so no prescaler is built in. In timer mode the count steps once per strobe. In counter mode the strobe is ignored and the count steps once per rising edge of an external event input, which is brought in through two synchronising flops. A debug-pause input blocks every step while it is high.

Three match channels each hold a compare value. A channel hits when a step would carry the count onto its value. A hit sets that channel's sticky flag and applies the channel's action. The action either lets the count continue, stops the timer, or returns the count to zero. Each flag can raise the interrupt output through its own enable. Two capture channels each synchronise an input pin and copy the present count into a capture register on the edges chosen for that channel. Software drives all of this through a flat word-wide register port: a write strobe, an address and write data, with read data decoded from the address in the same cycle.

The register offsets are: 0 control, 1 count, 2 to 4 match values of channels 0 to 2, 5 match configuration, 6 match flags, 7 capture configuration, 8 and 9 capture registers of channels 0 and 1. The reset input is asynchronous active-low. Its release passes through a two-flop synchroniser, so the block leaves reset two clock edges after the pin rises.

Top module: `mtc_timer`

## Requirements
- R1: After reset the count, control, match values, both configuration registers, the flags and both capture registers read 0, and irq_o is 0.
- R2: In timer mode (control bit 1 = 0), with control bit 0 (enable) set, each cycle with tick_i high adds one to the count. With no tick the count holds.
- R3: In counter mode (control bit 1 = 1), the count adds one per rising edge of event_i, seen after two synchronising flops. tick_i has no effect on the count.
- R4: While dbg_pause_i is high, no step happens and the count holds. Counting resumes when the pause input falls.
- R5: Channel i hits when a step would make the count equal its match value. The hit sets bit i of the flag register (offset 6). The flag stays set until a write to offset 6 has a 1 in bit i. A 0 in that bit leaves the flag alone.
- R6: Match configuration (offset 5) gives channel i the field in bits 3i+2..3i. Bits 3i+1..3i hold the action and bit 3i+2 the interrupt enable. For action 0 (continue), a hit loads the match value into the count and counting goes on.
- R7: For action 1 (stop), a hit loads the match value into the count and clears the enable bit. Further ticks leave the count unchanged.
- R8: For action 2 (reset), a hit loads 0 into the count instead of the match value.
- R9: When several channels hit on the same step, stop overrides reset and reset overrides continue. All of the hit channels set their flags.
- R10: irq_o is high exactly when some flag bit is set and that channel's interrupt-enable bit is set.
- R11: Capture configuration (offset 7) gives channel j bits 2j+1..2j: 0 off, 1 rising edge, 2 falling edge, 3 both edges. On a selected edge of cap_i[j], seen after two synchronising flops, the count is copied into the capture register of channel j.
- R12: A step from count 0xFFFFFFFF gives count 0.
- R13: A write to offset 1 loads the count directly, taking priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle reference strobe (timer mode) |
| event_i | input | 1 | External event input (counter mode) |
| cap_i | input | 2 | Capture trigger inputs |
| dbg_pause_i | input | 1 | Freezes counting while high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is two channels hitting on the same step with conflicting actions, because the count has to be walked onto a value that both channels share. The stimulus stops the timer first, so the count is parked at a known value. It then loads the same compare value into a stop channel and a reset channel and re-enables the timer. A further tick moves a third, continuing channel onto its value. One more tick then fires the conflicting pair, and the expected result is the match value held with the enable cleared. Capture edges are checked with the count frozen, which removes the synchroniser delay as a source of ambiguity.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    ACT_CONT  = 2'd0,
    ACT_STOP  = 2'd1,
    ACT_RESET = 2'd2,
    ACT_SPARE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_e;

  localparam int MCFG_W        = 3;
  localparam int CCFG_W        = 2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/mtc_rst_sync.sv
module mtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_ns = r2_q;
endmodule

// File: rtl/mtc_sync_edge.sv
module mtc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic lvl_o,
  output logic prev_o
);
  logic s1_q, s2_q, s3_q;
  logic s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = in_i;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/mtc_match_unit.sv
module mtc_match_unit
  import mtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_inc_i,
  input  logic [1:0]       act_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o,
  output logic             stop_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] val_q, val_d;
  logic             flag_q, flag_d;
  logic             hit;
  act_e             act;

  always_comb begin
    act    = act_e'(act_i);
    hit    = step_i && (cnt_inc_i == val_q);
    val_d  = wr_val_i ? wdata_i : val_q;
    flag_d = (flag_q && !clr_i) || hit;
    stop_o = hit && (act == ACT_STOP);
    zero_o = hit && (act == ACT_RESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      flag_q <= flag_d;
    end
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/mtc_capture_unit.sv
module mtc_capture_unit
  import mtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o
);
  logic             lvl, prev, rise, fall, take;
  logic [CNT_W-1:0] cap_q, cap_d;
  edge_e            sel;

  mtc_sync_edge u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_i   (cap_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  always_comb begin
    sel  = edge_e'(sel_i);
    rise = lvl && !prev;
    fall = !lvl && prev;
    unique case (sel)
      EDG_RISE: take = rise;
      EDG_FALL: take = fall;
      EDG_BOTH: take = rise || fall;
      default:  take = 1'b0;
    endcase
    cap_d = take ? count_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
  import mtc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3,
  parameter int N_CAP   = 2,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              event_i,
  input  logic [N_CAP-1:0]  cap_i,
  input  logic              dbg_pause_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int A_CTRL    = 0;
  localparam int A_COUNT   = 1;
  localparam int A_MATCH0  = 2;
  localparam int A_MCFG    = A_MATCH0 + N_MATCH;
  localparam int A_IFLAG   = A_MCFG + 1;
  localparam int A_CCFG    = A_MCFG + 2;
  localparam int A_CAP0    = A_MCFG + 3;
  localparam int MCFG_BITS = N_MATCH * MCFG_W;
  localparam int CCFG_BITS = N_CAP * CCFG_W;

  logic                 rst_ns;
  logic                 en_q, en_d, mode_q, mode_d;
  logic [CNT_W-1:0]     count_q, count_d, cnt_inc;
  logic [MCFG_BITS-1:0] mcfg_q, mcfg_d;
  logic [CCFG_BITS-1:0] ccfg_q, ccfg_d;
  logic                 wr_ctrl, wr_count, wr_mcfg, wr_iflag, wr_ccfg;
  logic [N_MATCH-1:0]   wr_match, flags, ien, stop_vec, zero_vec;
  logic                 any_stop, any_reset, step;
  logic                 ev_lvl, ev_prev, ev_rise;
  logic [CNT_W-1:0]     match_val [N_MATCH];
  logic [CNT_W-1:0]     cap_val   [N_CAP];

  mtc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  mtc_sync_edge u_ev (
    .clk    (clk),
    .rst_n  (rst_ns),
    .in_i   (event_i),
    .lvl_o  (ev_lvl),
    .prev_o (ev_prev)
  );

  always_comb begin
    wr_ctrl  = reg_wr_i && (reg_addr_i == ADDR_W'(A_CTRL));
    wr_count = reg_wr_i && (reg_addr_i == ADDR_W'(A_COUNT));
    wr_mcfg  = reg_wr_i && (reg_addr_i == ADDR_W'(A_MCFG));
    wr_iflag = reg_wr_i && (reg_addr_i == ADDR_W'(A_IFLAG));
    wr_ccfg  = reg_wr_i && (reg_addr_i == ADDR_W'(A_CCFG));
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_MATCH; gi++) begin : g_match
      assign wr_match[gi] = reg_wr_i && (reg_addr_i == ADDR_W'(A_MATCH0 + gi));
      assign ien[gi]      = mcfg_q[gi*MCFG_W + 2];
      mtc_match_unit #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_ns),
        .wr_val_i  (wr_match[gi]),
        .wdata_i   (reg_wdata_i),
        .step_i    (step),
        .cnt_inc_i (cnt_inc),
        .act_i     (mcfg_q[gi*MCFG_W +: 2]),
        .clr_i     (wr_iflag && reg_wdata_i[gi]),
        .val_o     (match_val[gi]),
        .flag_o    (flags[gi]),
        .stop_o    (stop_vec[gi]),
        .zero_o    (zero_vec[gi])
      );
    end
    for (gi = 0; gi < N_CAP; gi++) begin : g_cap
      mtc_capture_unit #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_ns),
        .cap_i   (cap_i[gi]),
        .sel_i   (ccfg_q[gi*CCFG_W +: CCFG_W]),
        .count_i (count_q),
        .cap_o   (cap_val[gi])
      );
    end
  endgenerate

  always_comb begin
    ev_rise   = ev_lvl && !ev_prev;
    cnt_inc   = count_q + CNT_W'(1);
    step      = en_q && !dbg_pause_i && (mode_q ? ev_rise : tick_i);
    any_stop  = |stop_vec;
    any_reset = |zero_vec;
    count_d   = count_q;
    en_d      = en_q;
    mode_d    = mode_q;
    mcfg_d    = wr_mcfg ? reg_wdata_i[MCFG_BITS-1:0] : mcfg_q;
    ccfg_d    = wr_ccfg ? reg_wdata_i[CCFG_BITS-1:0] : ccfg_q;
    if (wr_count)  count_d = reg_wdata_i;
    else if (step) count_d = (any_reset && !any_stop) ? '0 : cnt_inc;
    if (wr_ctrl) begin
      en_d   = reg_wdata_i[CTRL_EN_BIT];
      mode_d = reg_wdata_i[CTRL_MODE_BIT];
    end else if (step && any_stop) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      count_q <= '0;
      mcfg_q  <= '0;
      ccfg_q  <= '0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      count_q <= count_d;
      mcfg_q  <= mcfg_d;
      ccfg_q  <= ccfg_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_CTRL)) begin
      reg_rdata_o[CTRL_EN_BIT]   = en_q;
      reg_rdata_o[CTRL_MODE_BIT] = mode_q;
    end
    if (reg_addr_i == ADDR_W'(A_COUNT)) reg_rdata_o = count_q;
    if (reg_addr_i == ADDR_W'(A_MCFG))  reg_rdata_o[MCFG_BITS-1:0] = mcfg_q;
    if (reg_addr_i == ADDR_W'(A_IFLAG)) reg_rdata_o[N_MATCH-1:0] = flags;
    if (reg_addr_i == ADDR_W'(A_CCFG))  reg_rdata_o[CCFG_BITS-1:0] = ccfg_q;
    for (int i = 0; i < N_MATCH; i++)
      if (reg_addr_i == ADDR_W'(A_MATCH0 + i)) reg_rdata_o = match_val[i];
    for (int j = 0; j < N_CAP; j++)
      if (reg_addr_i == ADDR_W'(A_CAP0 + j)) reg_rdata_o = cap_val[j];
  end

  assign irq_o = |(flags & ien);
endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 3
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               step,
  input logic [CNT_W-1:0]   count_q,
  input logic               en_q,
  input logic               wr_count,
  input logic               wr_ctrl,
  input logic               wr_iflag,
  input logic               any_stop,
  input logic               any_reset,
  input logic [N_MATCH-1:0] flags,
  input logic [N_MATCH-1:0] ien,
  input logic               irq_o
);
  p_pause_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (!step && !wr_count) |=> $stable(count_q));

  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (step && !any_stop && !any_reset && !wr_count) |=> (count_q == $past(count_q) + CNT_W'(1)));

  p_reset_zero_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (step && any_reset && !any_stop && !wr_count) |=> (count_q == '0));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (step && any_stop && !wr_ctrl) |=> !en_q);

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (step && any_stop && any_reset && !wr_count) |=> (count_q == $past(count_q) + CNT_W'(1)));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_iflag |=> ((flags & $past(flags)) == $past(flags)));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (|(flags & ien)));
endmodule

bind mtc_timer mtc_timer_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .step      (step),
  .count_q   (count_q),
  .en_q      (en_q),
  .wr_count  (wr_count),
  .wr_ctrl   (wr_ctrl),
  .wr_iflag  (wr_iflag),
  .any_stop  (any_stop),
  .any_reset (any_reset),
  .flags     (flags),
  .ien       (ien),
  .irq_o     (irq_o)
);

// File: tb/mtc_timer_test.sv
module mtc_timer_test;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        event_i;
  logic [1:0]  cap_i;
  logic        dbg_pause_i;
  logic        reg_wr_i;
  logic [3:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks;
  int failures;
  bit done;

  mtc_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .event_i     (event_i),
    .cap_i       (cap_i),
    .dbg_pause_i (dbg_pause_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 write, 1 read-compare, 2 tick N times, 3 compare irq_o
  localparam int NV = 35;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 4'd6,  4'd5, 32'h0000_008C}, // R6 R7 R8: ch0 continue+ien, ch1 stop, ch2 reset
    {2'd0, 4'd5,  4'd2, 32'd3},         // R5
    {2'd0, 4'd7,  4'd3, 32'd100},       // R7
    {2'd0, 4'd8,  4'd4, 32'd5},         // R8
    {2'd0, 4'd2,  4'd0, 32'd1},         // R2 enable, timer mode
    {2'd2, 4'd2,  4'd0, 32'd2},         // R2
    {2'd1, 4'd2,  4'd1, 32'd2},         // R2
    {2'd2, 4'd6,  4'd0, 32'd1},         // R6
    {2'd1, 4'd6,  4'd1, 32'd3},         // R6 continue takes match value
    {2'd1, 4'd5,  4'd6, 32'd1},         // R5
    {2'd3, 4'd10, 4'd0, 32'd1},         // R10
    {2'd2, 4'd8,  4'd0, 32'd2},         // R8
    {2'd1, 4'd8,  4'd1, 32'd0},         // R8 reset to zero
    {2'd1, 4'd5,  4'd6, 32'd5},         // R5
    {2'd0, 4'd5,  4'd6, 32'd1},         // R5 clear bit0
    {2'd1, 4'd5,  4'd6, 32'd4},         // R5
    {2'd3, 4'd10, 4'd0, 32'd0},         // R10 ch2 flag masked
    {2'd0, 4'd5,  4'd6, 32'd0},         // R5 zero write
    {2'd1, 4'd5,  4'd6, 32'd4},         // R5
    {2'd0, 4'd7,  4'd3, 32'd2},         // R7
    {2'd2, 4'd7,  4'd0, 32'd2},         // R7
    {2'd1, 4'd7,  4'd1, 32'd2},         // R7
    {2'd1, 4'd7,  4'd0, 32'd0},         // R7 enable cleared
    {2'd2, 4'd7,  4'd0, 32'd1},         // R7
    {2'd1, 4'd7,  4'd1, 32'd2},         // R7 held after stop
    {2'd1, 4'd5,  4'd6, 32'd6},         // R5
    {2'd0, 4'd9,  4'd3, 32'd4},         // R9
    {2'd0, 4'd9,  4'd4, 32'd4},         // R9
    {2'd0, 4'd9,  4'd0, 32'd1},         // R9
    {2'd2, 4'd9,  4'd0, 32'd2},         // R9
    {2'd1, 4'd9,  4'd1, 32'd4},         // R9 stop beats reset
    {2'd1, 4'd9,  4'd0, 32'd0},         // R9
    {2'd1, 4'd9,  4'd6, 32'd7},         // R9 all flags
    {2'd0, 4'd13, 4'd1, 32'h20},        // R13
    {2'd1, 4'd13, 4'd1, 32'h20}         // R13
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input int rq, input logic [3:0] a, input logic [31:0] exp, input string what);
    reg_addr_i = a;
    #1;
    chk(rq, reg_rdata_o, exp, what);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; tick_i = 1'b0; event_i = 1'b0; cap_i = 2'b00;
    dbg_pause_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(1, 4'd1, 32'd0, "count after reset");
    rd(1, 4'd0, 32'd0, "ctrl after reset");
    rd(1, 4'd2, 32'd0, "match0 after reset");
    rd(1, 4'd5, 32'd0, "mcfg after reset");
    rd(1, 4'd6, 32'd0, "flags after reset");
    rd(1, 4'd7, 32'd0, "ccfg after reset");
    rd(1, 4'd8, 32'd0, "cap0 after reset");
    rd(1, 4'd9, 32'd0, "cap1 after reset");
    chk(1, {31'd0, irq_o}, 32'd0, "irq after reset");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][41:40])
        2'd0: wr(VEC[v][35:32], VEC[v][31:0]);
        2'd1: rd(int'(VEC[v][39:36]), VEC[v][35:32], VEC[v][31:0], $sformatf("vec %0d read", v));
        2'd2: ticks(int'(VEC[v][31:0]));
        default: chk(int'(VEC[v][39:36]), {31'd0, irq_o}, VEC[v][31:0], $sformatf("vec %0d irq", v));
      endcase
    end

    // R4 pause freezes
    wr(4'd1, 32'd10);
    wr(4'd0, 32'd1);
    dbg_pause_i = 1'b1;
    ticks(3);
    rd(4, 4'd1, 32'd10, "count during pause");
    dbg_pause_i = 1'b0;
    ticks(1);
    rd(4, 4'd1, 32'd11, "count after pause");

    // R2 no tick, no change
    idle(5);
    rd(2, 4'd1, 32'd11, "count without ticks");

    // R12 wrap
    wr(4'd1, 32'hFFFF_FFFF);
    ticks(1);
    rd(12, 4'd1, 32'd0, "count after wrap");

    // R3 counter mode
    wr(4'd0, 32'd3);
    ticks(3);
    rd(3, 4'd1, 32'd0, "ticks ignored in counter mode");
    for (int e = 0; e < 2; e++) begin
      @(negedge clk); event_i = 1'b1;
      idle(3);
      event_i = 1'b0;
      idle(4);
    end
    rd(3, 4'd1, 32'd2, "event edges counted");

    // R11 capture
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h55);
    wr(4'd7, 32'd9);
    cap_i = 2'b11;
    idle(5);
    rd(11, 4'd8, 32'h55, "cap0 rising");
    rd(11, 4'd9, 32'h0, "cap1 ignores rising");
    wr(4'd1, 32'h66);
    cap_i = 2'b00;
    idle(5);
    rd(11, 4'd8, 32'h55, "cap0 ignores falling");
    rd(11, 4'd9, 32'h66, "cap1 falling");
    wr(4'd7, 32'd3);
    wr(4'd1, 32'h77);
    cap_i = 2'b11;
    idle(5);
    rd(11, 4'd8, 32'h77, "cap0 both edges");
    rd(11, 4'd9, 32'h66, "cap1 off");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R0 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule